// File: doc/BRIEF.md
# Interrupt Request and Vector Selector

This block turns the status flags of a host-to-network message interface into one interrupt request line and, when the interrupt is acknowledged, a vector address. The request is the OR of several masked flag combinations: an error that is not already reported as an interrupt condition, a ready flag that is paired with an interrupt condition, a host error whose interrupt is not inhibited, an input transfer that has finished on its last word, and any completed output transfer.

When the interrupt is acknowledged, the block picks a vector by fixed priority. An input completion that did not end on the last word selects the base vector. Otherwise a completed output selects the base plus four. If neither applies, the vector is zero, which means no source is claimed. The base vector is an input, with octal 250 as the usual value, and its low two bits are always forced to zero. The request and the vector are both registered. Bus arbitration and priority levels are handled outside this block.

Top module: `irq_vector_select`

## Requirements
- R1: While reset (`rstN` low) is asserted, `irqReq` is 0 and `vectorOut` is 0.
- R2: If `errFlag` is 1 and `intCond` is 0 at a rising clock edge, `irqReq` is 1 after that edge.
- R3: If `ready` and `intCond` are both 1 at an edge, `irqReq` is 1 after it. `ready` alone does not raise a request.
- R4: If `hostErr` is 1 and `inhibitHostErr` is 0 at an edge, `irqReq` is 1 after it. With the inhibit set, the host error does not raise a request.
- R5: If `inDone` and `lastWord` are both 1 at an edge, `irqReq` is 1 after it. `inDone` alone does not raise a request.
- R6: If `outDone` is 1 at an edge, `irqReq` is 1 after it.
- R7: If none of the conditions in R2 to R6 holds at an edge, `irqReq` is 0 after it. The request therefore drops one cycle after its causing flags clear.
- R8: If `ack` is 1 at an edge while `inDone` is 1 and `lastWord` is 0, then after that edge `vectorOut` equals the base vector. This holds even when `outDone` is also 1.
- R9: If `ack` is 1 at an edge, R8 does not apply and `outDone` is 1, then after that edge `vectorOut` equals the base vector plus 4.
- R10: If `ack` is 1 at an edge and neither R8 nor R9 applies, then after that edge `vectorOut` is 0.
- R11: If `ack` is 0 at an edge, `vectorOut` keeps its value.
- R12: The base vector used in R8 and R9 is `baseVector` with bits 1:0 cleared. Bits 1:0 of `vectorOut` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inDone | input | 1 | Input transfer completed |
| lastWord | input | 1 | Input completion ended on the last word |
| outDone | input | 1 | Output transfer completed |
| errFlag | input | 1 | Interface error |
| ready | input | 1 | Remote side ready |
| intCond | input | 1 | Interrupt condition pending |
| hostErr | input | 1 | Host error |
| inhibitHostErr | input | 1 | Suppress the interrupt on host error |
| ack | input | 1 | Interrupt acknowledge; loads the vector |
| baseVector | input | 16 | Base vector (usually octal 250) |
| irqReq | output | 1 | Registered interrupt request |
| vectorOut | output | 16 | Vector chosen at the last acknowledge |

## Verification
Each request term is driven on its own and then with its mask bit set. This separates the masked equation from a plain OR of the flags. The acknowledge cases pair input done with output done, with and without last word, which tells input-first priority apart from output-first priority and from ignoring the last-word exclusion. Cycles with acknowledge low, an unaligned base, and a reset in the middle of a run show that the vector holds, that the alignment masking is applied, and that the reset clears both outputs.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;

  typedef struct packed {
    logic inDone;
    logic lastWord;
    logic outDone;
    logic errFlag;
    logic ready;
    logic intCond;
    logic hostErr;
    logic inhibitHostErr;
  } statusFlags_t;

  typedef struct packed {
    logic reqNext;
    logic loadVec;
    logic pickIn;
    logic pickOut;
  } vecCtrl_t;

endpackage

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vector_pkg::*;
(
  input  statusFlags_t flags,
  input  logic         ack,
  output vecCtrl_t     ctrl
);

  logic errTerm;
  logic readyTerm;
  logic hostTerm;
  logic lastTerm;
  logic outTerm;

  always_comb begin
    errTerm   = flags.errFlag & ~flags.intCond;
    readyTerm = flags.ready & flags.intCond;
    hostTerm  = flags.hostErr & ~flags.inhibitHostErr;
    lastTerm  = flags.inDone & flags.lastWord;
    outTerm   = flags.outDone;

    ctrl.reqNext = errTerm | readyTerm | hostTerm | lastTerm | outTerm;
    ctrl.loadVec = ack;
    // input completion without last word wins over output completion
    ctrl.pickIn  = flags.inDone & ~flags.lastWord;
    ctrl.pickOut = ~ctrl.pickIn & flags.outDone;
  end

endmodule

// File: rtl/irq_vector_dp.sv
module irq_vector_dp
  import irq_vector_pkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int ALIGN    = 2,
  parameter int OUT_STEP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  vecCtrl_t         ctrl,
  input  logic [VEC_W-1:0] baseVector,
  output logic             irqReq,
  output logic [VEC_W-1:0] vectorOut
);

  localparam logic [VEC_W-1:0] STEP = VEC_W'(OUT_STEP);

  logic [VEC_W-1:0] alignedBase;
  logic [VEC_W-1:0] vecNext;

  generate
    if (ALIGN > 0) begin : g_align
      always_comb begin
        alignedBase = baseVector;
        alignedBase[ALIGN-1:0] = '0;
      end
    end else begin : g_noAlign
      always_comb alignedBase = baseVector;
    end
  endgenerate

  always_comb begin
    if (ctrl.pickIn)       vecNext = alignedBase;
    else if (ctrl.pickOut) vecNext = alignedBase + STEP;
    else                   vecNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqReq    <= 1'b0;
      vectorOut <= '0;
    end else begin
      irqReq <= ctrl.reqNext;
      if (ctrl.loadVec) vectorOut <= vecNext;
    end
  end

endmodule

// File: rtl/irq_vector_select.sv
module irq_vector_select
  import irq_vector_pkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int ALIGN    = 2,
  parameter int OUT_STEP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inDone,
  input  logic             lastWord,
  input  logic             outDone,
  input  logic             errFlag,
  input  logic             ready,
  input  logic             intCond,
  input  logic             hostErr,
  input  logic             inhibitHostErr,
  input  logic             ack,
  input  logic [VEC_W-1:0] baseVector,
  output logic             irqReq,
  output logic [VEC_W-1:0] vectorOut
);

  statusFlags_t flags;
  vecCtrl_t     ctrl;

  always_comb begin
    flags.inDone         = inDone;
    flags.lastWord       = lastWord;
    flags.outDone        = outDone;
    flags.errFlag        = errFlag;
    flags.ready          = ready;
    flags.intCond        = intCond;
    flags.hostErr        = hostErr;
    flags.inhibitHostErr = inhibitHostErr;
  end

  irq_vector_ctrl i_ctrl (
    .flags (flags),
    .ack   (ack),
    .ctrl  (ctrl)
  );

  irq_vector_dp #(
    .VEC_W    (VEC_W),
    .ALIGN    (ALIGN),
    .OUT_STEP (OUT_STEP)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .baseVector (baseVector),
    .irqReq     (irqReq),
    .vectorOut  (vectorOut)
  );

endmodule

// File: rtl/irq_vector_select_chk.sv
module irq_vector_select_chk #(
  parameter int VEC_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             inDone,
  input logic             lastWord,
  input logic             outDone,
  input logic             errFlag,
  input logic             ready,
  input logic             intCond,
  input logic             hostErr,
  input logic             inhibitHostErr,
  input logic             ack,
  input logic [VEC_W-1:0] baseVector,
  input logic             irqReq,
  input logic [VEC_W-1:0] vectorOut
);

  logic anyCause;
  logic [VEC_W-1:0] baseMasked;
  always_comb begin
    anyCause = (errFlag && !intCond) || (ready && intCond) ||
               (hostErr && !inhibitHostErr) || (inDone && lastWord) || outDone;
    baseMasked = baseVector & ~VEC_W'(3);
  end

  assert_rst_clear_R1: assert property (@(posedge clk)
    !rstN |=> (irqReq == 1'b0 && vectorOut == '0));

  assert_err_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !intCond) |=> irqReq);

  assert_ready_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ready && intCond) |=> irqReq);

  assert_host_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hostErr && !inhibitHostErr) |=> irqReq);

  assert_last_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inDone && lastWord) |=> irqReq);

  assert_out_req_R6: assert property (@(posedge clk) disable iff (!rstN)
    outDone |=> irqReq);

  assert_no_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    !anyCause |=> !irqReq);

  assert_vec_in_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ack && inDone && !lastWord) |=> vectorOut == $past(baseMasked));

  assert_vec_out_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !(inDone && !lastWord) && outDone) |=>
      vectorOut == $past(baseMasked) + VEC_W'(4));

  assert_vec_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !(inDone && !lastWord) && !outDone) |=> vectorOut == '0);

  assert_vec_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !ack |=> $stable(vectorOut));

  assert_vec_align_R12: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> vectorOut[1:0] == 2'b00);

endmodule

bind irq_vector_select irq_vector_select_chk #(.VEC_W(VEC_W)) i_chk (.*);

// File: tb/test_irq_vector_select.sv
module test_irq_vector_select;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  flagBus = '0;   // {inDone,lastWord,outDone,errFlag,ready,intCond,hostErr,inhibitHostErr}
  logic        ack = 1'b0;
  logic [15:0] baseVector = 16'o250;
  logic        irqReq;
  logic [15:0] vectorOut;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_select i_irq_vector_select (
    .clk            (clk),
    .rstN           (rstN),
    .inDone         (flagBus[7]),
    .lastWord       (flagBus[6]),
    .outDone        (flagBus[5]),
    .errFlag        (flagBus[4]),
    .ready          (flagBus[3]),
    .intCond        (flagBus[2]),
    .hostErr        (flagBus[1]),
    .inhibitHostErr (flagBus[0]),
    .ack            (ack),
    .baseVector     (baseVector),
    .irqReq         (irqReq),
    .vectorOut      (vectorOut)
  );

  // row: flags(8) ack(1) base(16) expIrq(1) expVec(16) reqNum(8)
  typedef logic [49:0] row_t;
  localparam row_t TABLE [NVEC] = '{
    {8'b0000_0000, 1'b0, 16'o250,  1'b0, 16'h0000, 8'd7},   // R7 idle
    {8'b0001_0000, 1'b0, 16'o250,  1'b1, 16'h0000, 8'd2},   // R2 error alone
    {8'b0001_0100, 1'b0, 16'o250,  1'b0, 16'h0000, 8'd2},   // R2 masked by intCond
    {8'b0000_1100, 1'b0, 16'o250,  1'b1, 16'h0000, 8'd3},   // R3 ready+intCond
    {8'b0000_1000, 1'b0, 16'o250,  1'b0, 16'h0000, 8'd3},   // R3 ready alone
    {8'b0000_0010, 1'b0, 16'o250,  1'b1, 16'h0000, 8'd4},   // R4 host error
    {8'b0000_0011, 1'b0, 16'o250,  1'b0, 16'h0000, 8'd4},   // R4 inhibited
    {8'b1100_0000, 1'b0, 16'o250,  1'b1, 16'h0000, 8'd5},   // R5 last word
    {8'b1000_0000, 1'b1, 16'o250,  1'b0, 16'o250,  8'd8},   // R8 input vector
    {8'b1010_0000, 1'b1, 16'o250,  1'b1, 16'o250,  8'd8},   // R8 input beats output, R6
    {8'b1110_0000, 1'b1, 16'o250,  1'b1, 16'o254,  8'd9},   // R9 last word excluded
    {8'b0010_0000, 1'b0, 16'o300,  1'b1, 16'o254,  8'd11},  // R11 hold, R6
    {8'b0000_0000, 1'b1, 16'o250,  1'b0, 16'h0000, 8'd10},  // R10 no source
    {8'b1000_0000, 1'b1, 16'hFFFF, 1'b0, 16'hFFFC, 8'd12},  // R12 alignment
    {8'b0010_0000, 1'b1, 16'h1233, 1'b1, 16'h1234, 8'd12},  // R12 aligned plus step
    {8'b0000_0000, 1'b0, 16'h0000, 1'b0, 16'h1234, 8'd11}   // R11 hold
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (10000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 irq", {15'b0, irqReq}, 16'h0);
    check("R1 vector", vectorOut, 16'h0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      row_t r;
      r = TABLE[i];
      flagBus    = r[49:42];
      ack        = r[41];
      baseVector = r[40:25];
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0d irq row %0d", r[7:0], i), {15'b0, irqReq}, {15'b0, r[24]});
      check($sformatf("R%0d vector row %0d", r[7:0], i), vectorOut, r[23:8]);
    end

    // R7: request drops one cycle after the cause clears
    flagBus = 8'b0010_0000; ack = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R6 irq set", {15'b0, irqReq}, 16'h1);
    flagBus = 8'b0000_0000;
    @(posedge clk); @(negedge clk);
    check("R7 irq cleared", {15'b0, irqReq}, 16'h0);

    // R1: mid-run reset clears both outputs
    flagBus = 8'b1010_0000; ack = 1'b1; baseVector = 16'o250;
    @(posedge clk); @(negedge clk);
    check("R8 before reset", vectorOut, 16'o250);
    rstN = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 irq mid reset", {15'b0, irqReq}, 16'h0);
    check("R1 vector mid reset", vectorOut, 16'h0);
    rstN = 1'b1; flagBus = '0; ack = 1'b0;
    @(posedge clk); @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule